// File: doc/BRIEF.md
# Serial Register-Access Port Controller

This block is the slave side of a serial port through which a host reads and writes a bank of registers. Every access starts with a one-byte instruction. The instruction carries a read/write flag and a register address. A data phase follows, and its length is the byte width of the addressed register. That width comes from an external lookup, so the port always moves a whole register and not a single byte. After the last byte, the next serial clock edges are taken as a fresh instruction. This lets several accesses run back to back under one chip select.

The chip-select, serial clock and data lines are sampled with a fast system clock. The port runs in two lane modes. In single-lane mode one bit moves per serial clock edge on line 0. In nibble mode four bits move per edge on lines 3..0, which gives four times the throughput. Writes collect bytes and hand them to the register bank as one write with byte enables. Reads fetch the register through the same lookup and shift it out on the falling edges. A synchronous abort input, or releasing chip select, cuts an access short. In that case only the bytes that were fully received are written.

Top module: `serport_ctrl`

## Requirements
- R1: Instruction byte layout: bit 7 = 1 requests a read and 0 a write, bits 6 and 5 have no effect, bits 4:0 select the register address.
- R2: Instruction and write-data bits are taken on rising SCLK edges, most significant bit first, after a two-stage synchronizer in the system clock domain.
- R3: The data phase moves exactly the number of bytes the lookup reports for the address (1..4). A lookup value of 0 means no register: the access is one byte long and reads return zero. After the last byte the next edges form a new instruction, even with chip select still low.
- R4: A write that completes produces one single-cycle `wr_en` pulse. The register's most significant byte is sent first and lands in lane width-1 of `wr_data`. Lane k is bits 8k+7:8k. `wr_be[k]` is set for each written lane, and lanes that are not enabled read as zero.
- R5: Read data is launched on falling SCLK edges, most significant byte and bit first. It is valid before the following rising edge when SCLK is held low for more than three system clocks.
- R6: `sdio_oe` is nonzero only during the data phase of a read. It is 4'b0001 in single-lane mode and 4'b1111 in nibble mode.
- R7: A `sync_abort` pulse ends the access at once. A write then commits only the whole bytes already received, with their lanes and enables placed as in R4, and issues no write if no byte completed. Output drive stops on the next clock, and the following edges form a new instruction.
- R8: Raising `cs_n` ends the access in the same way as an abort, discards a partly received instruction, and restarts bit and byte counting.
- R9: With `quad_mode` = 1, four bits move per SCLK edge on lines 3..0, line 3 carrying the most significant bit. This applies to both the instruction and the data, so a byte takes two edges.
- R10: After reset, `wr_en` is 0 and `sdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 4 | Serial data lines as received |
| sdio_out | output | 4 | Serial data lines as driven during reads |
| sdio_oe | output | 4 | Per-line output enable |
| quad_mode | input | 1 | 1 = four lines per edge, 0 = line 0 only; stable during an access |
| sync_abort | input | 1 | Synchronous abort of the current access |
| look_addr | output | 5 | Address presented to the width lookup and read port |
| look_bytes | input | 3 | Byte width of the register at `look_addr`, 0 = absent |
| look_data | input | 32 | Current contents of the register at `look_addr` |
| wr_en | output | 1 | One-cycle write strobe to the register bank |
| wr_addr | output | 5 | Write address |
| wr_data | output | 32 | Write data, byte lane k holds register byte k |
| wr_be | output | 4 | Byte enables for `wr_data` |

## Verification
On every cycle, the assertions check four things: the output enable only ever takes one of its three legal codes, it is released one clock after an abort and while chip select has been high for three samples, and every write strobe is a single cycle with at least one byte enabled. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model. These are the lane placement of partial and complete writes, the bit order of read data in both lane modes, the width taken from the lookup (including absent registers), and the re-alignment to a new instruction after an abort, after chip select is released mid-instruction, and between back-to-back accesses.

// File: rtl/serport_pkg.sv
// Shared types for the serial register-access port.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package serport_pkg;

    // Access phase: instruction byte, one-clock width lookup, data bytes
    typedef enum logic [1:0] {
        PH_INSTR  = 2'd0,
        PH_LOOKUP = 2'd1,
        PH_DATA   = 2'd2
    } phase_t;

endpackage

// File: rtl/serport_sync.sv
// Two-stage synchronizer for a bundle of asynchronous inputs.
// Assumes every bit of the bundle is sampled together so that data
// lines and the serial clock keep their relative alignment.
module serport_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two flops in series, reset to the idle level of each input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/serport_rx.sv
// Byte assembler for incoming serial bits.
// Takes one bit (single lane) or four bits (nibble lane, bit 3 first)
// per shift strobe and flags the strobe on which a byte completes.
// Assumes the lane mode does not change within a byte.
module serport_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift_en,
    input  logic       quad,
    input  logic [3:0] bits,
    output logic       byte_done,
    output logic [7:0] byte_val
);

    logic [3:0] cnt;
    logic [7:0] sh;
    logic [3:0] cnt_nx;

    // Next byte image and completion flag for the current strobe
    always_comb begin
        byte_val  = quad ? {sh[3:0], bits} : {sh[6:0], bits[0]};
        cnt_nx    = cnt + (quad ? 4'd4 : 4'd1);
        byte_done = shift_en && (cnt_nx == 4'd8);
    end

    // Bit counter and shift register, restarted on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (clear) begin
            cnt <= '0;
            sh  <= '0;
        end else if (shift_en) begin
            sh  <= byte_val;
            cnt <= byte_done ? 4'd0 : cnt_nx;
        end
    end

endmodule

// File: rtl/serport_tx.sv
// Read-data shifter: loads a register image aligned to its top bits and
// presents one bit (line 0) or one nibble (lines 3..0) per shift strobe.
// Assumes the caller aligns the most significant register byte at the top.
module serport_tx #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              quad,
    output logic [3:0]        out_bits
);

    logic [DATA_W-1:0] sh;

    // Load the image, then move the top bits to the output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            out_bits <= '0;
        end else if (load) begin
            sh       <= load_val;
            out_bits <= '0;
        end else if (shift_en) begin
            if (quad) begin
                out_bits <= sh[DATA_W-1 -: 4];
                sh       <= sh << 4;
            end else begin
                out_bits <= {3'b000, sh[DATA_W-1]};
                sh       <= sh << 1;
            end
        end
    end

endmodule

// File: rtl/serport_ctrl.sv
// Serial register-access port, slave side.
// An access is an instruction byte (read flag, address) followed by as
// many data bytes as the addressed register holds. Writes are handed to
// the register bank as one strobe with byte enables; reads are fetched
// through the lookup port and shifted out on falling serial clock edges.
// Assumes: clk runs at least four times faster than sclk (eight for
// reads), quad_mode is stable while cs_n is low, sync_abort is
// synchronous to clk, and the lookup answers combinationally.
module serport_ctrl
    import serport_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MAX_BYTES = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cs_n,
    input  logic                               sclk,
    input  logic [3:0]                         sdio_in,
    output logic [3:0]                         sdio_out,
    output logic [3:0]                         sdio_oe,
    input  logic                               quad_mode,
    input  logic                               sync_abort,
    output logic [ADDR_W-1:0]                  look_addr,
    input  logic [$clog2(MAX_BYTES+1)-1:0]     look_bytes,
    input  logic [8*MAX_BYTES-1:0]             look_data,
    output logic                               wr_en,
    output logic [ADDR_W-1:0]                  wr_addr,
    output logic [8*MAX_BYTES-1:0]             wr_data,
    output logic [MAX_BYTES-1:0]               wr_be
);

    localparam int          DATA_W  = 8 * MAX_BYTES;
    localparam int          CNT_W   = $clog2(MAX_BYTES + 1);
    localparam int          SYN_W   = 6;
    localparam logic [5:0]  SYN_RST = 6'b10_0000;

    // ---- input synchronization and edge detection ----
    logic [SYN_W-1:0] syn_q;
    logic             cs_s, sclk_s, sclk_q;
    logic [3:0]       din_s;
    logic             rise, fall, end_early;

    serport_sync #(.W(SYN_W), .RST_VAL(SYN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdio_in}),
        .q     (syn_q)
    );

    assign {cs_s, sclk_s, din_s} = syn_q;

    // Previous synchronized serial clock, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise      = !cs_s && sclk_s && !sclk_q;
    assign fall      = !cs_s && !sclk_s && sclk_q;
    assign end_early = sync_abort || cs_s;

    // ---- access state ----
    phase_t               phase;
    logic                 is_rd;
    logic [ADDR_W-1:0]    addr;
    logic [CNT_W-1:0]     width;
    logic [CNT_W-1:0]     done;
    logic [DATA_W-1:0]    acc;

    // ---- byte assembly ----
    logic                 rx_shift, rx_done;
    logic [7:0]           rx_byte;

    assign rx_shift = rise && !end_early && (phase != PH_LOOKUP);

    serport_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (end_early),
        .shift_en  (rx_shift),
        .quad      (quad_mode),
        .bits      (din_s),
        .byte_done (rx_done),
        .byte_val  (rx_byte)
    );

    // ---- width resolution and read image ----
    logic                 present;
    logic [CNT_W-1:0]     w_res;
    logic [DATA_W-1:0]    rd_image;

    // Clamp the looked-up width; an absent register is one zero byte
    always_comb begin
        present = (look_bytes != '0);
        if (!present)
            w_res = CNT_W'(1);
        else if (look_bytes > CNT_W'(MAX_BYTES))
            w_res = CNT_W'(MAX_BYTES);
        else
            w_res = look_bytes;
        rd_image = present ? (look_data << (8 * (MAX_BYTES - int'(w_res)))) : '0;
    end

    // ---- read shifter ----
    logic       tx_load, tx_shift;
    logic [3:0] tx_bits;

    assign tx_load  = (phase == PH_LOOKUP) && !end_early;
    assign tx_shift = fall && !end_early && (phase == PH_DATA) && is_rd;

    serport_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_val (rd_image),
        .shift_en (tx_shift),
        .quad     (quad_mode),
        .out_bits (tx_bits)
    );

    // ---- write commit ----
    logic [CNT_W-1:0]     k_nx, cm_k;
    logic [DATA_W-1:0]    acc_nx, cm_acc, cm_data;
    logic [MAX_BYTES-1:0] cm_be;
    logic                 commit_now;

    // Byte count and collected bytes after this clock's strobe
    always_comb begin
        k_nx   = rx_done ? done + CNT_W'(1) : done;
        acc_nx = rx_done ? ((acc << 8) | DATA_W'(rx_byte)) : acc;
    end

    // Decide on a commit and place the collected bytes into their lanes
    always_comb begin
        commit_now = (phase == PH_DATA) && !is_rd &&
                     ((end_early && done != '0) ||
                      (!end_early && rx_done && k_nx == width));
        cm_k    = end_early ? done : k_nx;
        cm_acc  = end_early ? acc  : acc_nx;
        cm_data = cm_acc << (8 * (int'(width) - int'(cm_k)));
        for (int j = 0; j < MAX_BYTES; j++) begin
            cm_be[j] = (j < int'(width)) && (j >= int'(width) - int'(cm_k));
        end
    end

    // Access sequencing and the registered write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_INSTR;
            is_rd   <= 1'b0;
            addr    <= '0;
            width   <= CNT_W'(1);
            done    <= '0;
            acc     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_be   <= '0;
        end else begin
            wr_en <= commit_now;
            if (commit_now) begin
                wr_addr <= addr;
                wr_data <= cm_data;
                wr_be   <= cm_be;
            end
            if (end_early) begin
                phase <= PH_INSTR;
                done  <= '0;
                acc   <= '0;
            end else begin
                case (phase)
                    PH_INSTR: begin
                        if (rx_done) begin
                            is_rd <= rx_byte[7];
                            addr  <= rx_byte[ADDR_W-1:0];
                            phase <= PH_LOOKUP;
                        end
                    end
                    PH_LOOKUP: begin
                        width <= w_res;
                        done  <= '0;
                        acc   <= '0;
                        phase <= PH_DATA;
                    end
                    PH_DATA: begin
                        if (rx_done) begin
                            done <= k_nx;
                            acc  <= acc_nx;
                            if (k_nx == width) phase <= PH_INSTR;
                        end
                    end
                    default: phase <= PH_INSTR;
                endcase
            end
        end
    end

    // ---- outputs ----
    assign look_addr = addr;
    assign sdio_out  = tx_bits;
    assign sdio_oe   = ((phase == PH_DATA) && is_rd && !cs_s) ?
                       (quad_mode ? 4'hF : 4'h1) : 4'h0;

endmodule

// File: rtl/serport_ctrl_chk.sv
// Property checker for serport_ctrl, attached by bind.
// Assumes the checked signals are the top-level ports of the port.
module serport_ctrl_chk #(
    parameter int BE_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            sync_abort,
    input logic [3:0]      sdio_oe,
    input logic            wr_en,
    input logic [BE_W-1:0] wr_be
);

    // R6
    oe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe == 4'h0) || (sdio_oe == 4'h1) || (sdio_oe == 4'hF));

    // R4
    wr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be != '0));

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R7
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_abort |=> (sdio_oe == 4'h0));

    // R8
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> (sdio_oe == 4'h0));

endmodule

bind serport_ctrl serport_ctrl_chk #(.BE_W(MAX_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sync_abort (sync_abort),
    .sdio_oe    (sdio_oe),
    .wr_en      (wr_en),
    .wr_be      (wr_be)
);

// File: tb/test_serport_ctrl.sv
// Bench for serport_ctrl: a behavioural host and register bank, an
// expected-write queue compared on every clock, and bitwise read checks.
module test_serport_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 4;   // system clocks per SCLK half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        quad_mode = 1'b0;
    logic        sync_abort = 1'b0;
    logic [3:0]  sdio_in = 4'h0;
    logic [3:0]  sdio_out, sdio_oe;
    logic [4:0]  look_addr;
    logic [2:0]  look_bytes;
    logic [31:0] look_data;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;

    logic [31:0] mem [32];
    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;

    logic [4:0]  ea_q [$];
    logic [31:0] ed_q [$];
    logic [3:0]  eb_q [$];
    string       et_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    serport_ctrl i_serport_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdio_in    (sdio_in),
        .sdio_out   (sdio_out),
        .sdio_oe    (sdio_oe),
        .quad_mode  (quad_mode),
        .sync_abort (sync_abort),
        .look_addr  (look_addr),
        .look_bytes (look_bytes),
        .look_data  (look_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_be      (wr_be)
    );

    // Register widths of the bench's bank: 1..4 bytes below 16, absent above
    function automatic int wid(input logic [4:0] a);
        return (a < 5'd16) ? (int'(a) % 4) + 1 : 0;
    endfunction

    always_comb begin
        look_bytes = 3'(wid(look_addr));
        look_data  = mem[look_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Compare every write strobe with the model and apply it to the bank
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (ea_q.size() == 0) begin
                chk(1'b0, "R7 unexpected write", {27'd0, wr_addr}, 32'd0);
            end else begin
                logic [4:0]  ea;
                logic [31:0] ed;
                logic [3:0]  eb;
                string       et;
                ea = ea_q.pop_front();
                ed = ed_q.pop_front();
                eb = eb_q.pop_front();
                et = et_q.pop_front();
                chk(wr_addr == ea, {et, " write addr"}, {27'd0, wr_addr}, {27'd0, ea});
                chk(wr_data == ed, {et, " write data"}, wr_data, ed);
                chk(wr_be == eb, {et, " write enables"}, {28'd0, wr_be}, {28'd0, eb});
            end
            for (int j = 0; j < 4; j++)
                if (wr_be[j]) mem[wr_addr][8*j +: 8] = wr_data[8*j +: 8];
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // One host access: instruction, nbits of data, then optional abort/release
    task automatic xfer(input bit rd, input logic [4:0] a, input logic [1:0] jk,
                        input bit q, input int nbits, input logic [31:0] dv,
                        input bit abrt, input bit rel, input string req);
        int          w, step, k;
        logic [7:0]  ins;
        logic [31:0] rv, ed;
        logic [3:0]  nib, ex, eb;
        w = wid(a);
        if (w == 0) w = 1;
        step = q ? 4 : 1;
        ins = {rd, jk, a};
        quad_mode = q;
        if (!rd) begin
            k = nbits / 8;
            if (k > w) k = w;
            if (k > 0) begin
                ed = '0;
                eb = '0;
                for (int j = 0; j < k; j++) begin
                    ed[8*(w-1-j) +: 8] = dv[8*(w-1-j) +: 8];
                    eb[w-1-j] = 1'b1;
                end
                ea_q.push_back(a);
                ed_q.push_back(ed);
                eb_q.push_back(eb);
                et_q.push_back(req);
            end
        end
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int e = 0; e < 8 / step; e++) begin
            nib = '0;
            for (int b = 0; b < step; b++) nib[step-1-b] = ins[7-e*step-b];
            sdio_in = nib;
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        rv = (wid(a) == 0) ? 32'd0 : mem[a];
        for (int e = 0; e < nbits / step; e++) begin
            nib = '0;
            for (int b = 0; b < step; b++) nib[step-1-b] = dv[8*w-1-e*step-b];
            sdio_in = rd ? 4'hA : nib;
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            if (rd) begin
                ex = '0;
                for (int b = 0; b < step; b++) ex[step-1-b] = rv[8*w-1-e*step-b];
                if (q) chk(sdio_out == ex, {req, " read nibble"}, {28'd0, sdio_out}, {28'd0, ex});
                else   chk(sdio_out[0] == ex[0], {req, " read bit"}, {31'd0, sdio_out[0]}, {31'd0, ex[0]});
                chk(sdio_oe == (q ? 4'hF : 4'h1), "R6 read drive", {28'd0, sdio_oe},
                    q ? 32'hF : 32'h1);
            end else begin
                chk(sdio_oe == 4'h0, "R6 write no drive", {28'd0, sdio_oe}, 32'd0);
            end
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        if (abrt) begin
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            sync_abort = 1'b1;
            @(negedge clk);
            sync_abort = 1'b0;
            @(negedge clk);
            chk(sdio_oe == 4'h0, "R7 drive after abort", {28'd0, sdio_oe}, 32'd0);
            repeat (4) @(negedge clk);
        end
        if (rel) begin
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            cs_n = 1'b1;
            repeat (6) @(negedge clk);
            chk(sdio_oe == 4'h0, "R8 drive after release", {28'd0, sdio_oe}, 32'd0);
        end
    endtask

    // Stray edges with chip select low, then release mid-instruction
    task automatic stray(input int n);
        quad_mode = 1'b0;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int e = 0; e < n; e++) begin
            sdio_in = 4'hF;
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 32'h9E3779B9 * (i + 1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(wr_en == 1'b0, "R10 wr_en after reset", {31'd0, wr_en}, 32'd0);
        chk(sdio_oe == 4'h0, "R10 oe after reset", {28'd0, sdio_oe}, 32'd0);

        // R4 full four-byte write, R5 read back
        xfer(1'b0, 5'd3, 2'b00, 1'b0, 32, 32'hA1B2C3D4, 1'b0, 1'b1, "R4");
        xfer(1'b1, 5'd3, 2'b00, 1'b0, 32, 32'h0, 1'b0, 1'b1, "R5");
        // R2 one-byte register, bit order
        xfer(1'b0, 5'd0, 2'b00, 1'b0, 8, 32'h00000096, 1'b0, 1'b1, "R2");
        xfer(1'b1, 5'd0, 2'b00, 1'b0, 8, 32'h0, 1'b0, 1'b1, "R2");
        // R1 ignored instruction bits 6:5
        xfer(1'b0, 5'd1, 2'b11, 1'b0, 16, 32'h00005A3C, 1'b0, 1'b1, "R1");
        xfer(1'b1, 5'd1, 2'b10, 1'b0, 16, 32'h0, 1'b0, 1'b1, "R1");
        // R9 nibble mode write and read of a three-byte register
        xfer(1'b0, 5'd2, 2'b00, 1'b1, 24, 32'h00123456, 1'b0, 1'b1, "R9");
        xfer(1'b1, 5'd2, 2'b00, 1'b1, 24, 32'h0, 1'b0, 1'b1, "R9");
        // R7 abort after two bytes and three bits, then read merged value
        xfer(1'b0, 5'd7, 2'b00, 1'b0, 19, 32'hDEADBEEF, 1'b1, 1'b1, "R7");
        xfer(1'b1, 5'd7, 2'b00, 1'b0, 32, 32'h0, 1'b0, 1'b1, "R7");
        // R7 abort before any byte: no write; next instruction accepted
        xfer(1'b0, 5'd5, 2'b00, 1'b0, 5, 32'h0000FFFF, 1'b1, 1'b0, "R7");
        xfer(1'b0, 5'd5, 2'b00, 1'b0, 16, 32'h00004321, 1'b0, 1'b1, "R7");
        // R8 chip select released after one byte of a three-byte write
        xfer(1'b0, 5'd6, 2'b00, 1'b0, 10, 32'h00ABCDEF, 1'b0, 1'b1, "R8");
        // R8 release mid-instruction, then a clean access
        stray(3);
        xfer(1'b0, 5'd4, 2'b00, 1'b0, 8, 32'h0000005E, 1'b0, 1'b1, "R8");
        xfer(1'b1, 5'd4, 2'b00, 1'b0, 8, 32'h0, 1'b0, 1'b1, "R8");
        // R3 absent register: one byte, reads zero
        xfer(1'b0, 5'd20, 2'b00, 1'b0, 8, 32'h00000077, 1'b0, 1'b1, "R3");
        xfer(1'b1, 5'd20, 2'b00, 1'b0, 8, 32'h0, 1'b0, 1'b1, "R3");
        // R3 back-to-back accesses under one chip select
        xfer(1'b0, 5'd9, 2'b00, 1'b0, 16, 32'h0000BEEF, 1'b0, 1'b0, "R3");
        xfer(1'b1, 5'd9, 2'b00, 1'b0, 16, 32'h0, 1'b0, 1'b1, "R3");
        // R7 abort of a nibble-mode read
        xfer(1'b1, 5'd11, 2'b00, 1'b1, 12, 32'h0, 1'b1, 1'b1, "R7");

        repeat (10) @(negedge clk);
        chk(ea_q.size() == 0, "R4 expected writes outstanding", ea_q.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule